// File: doc/BRIEF.md
# Card Status Change Interrupt Register

This block is an 8-bit status register for a single PC card slot. A CPU reaches it over a plain write strobe and a read data bus. It holds two live bits. The first is a software card-detect-change flag, which lets firmware inject the same interrupt that a hardware card-detect change would raise. The second is an IREQ request bit, which follows the card's active-low interrupt request pin. The block combines both sources into one active-high interrupt line.

The IREQ bit has three behaviours, chosen by a two-bit mode input that comes from the companion enable register:

- **Pulse mode:** the bit latches a synchronized falling edge of the pin and stays set until software clears it.
- **Level mode:** the bit is a read-only view of the synchronized pin.
- **Disabled:** the bit stays at zero.

When the slot holds a memory card rather than an I/O card, the IREQ bit is forced to zero.

Only bit 7 and bit 5 are implemented. Every other bit of the register reads zero.

Top module: `csc_status_reg`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and `irq` is 0.
- R2: A write with data bit 7 = 1 sets the software detect bit (read at `rd_data[7]`). It stays set across cycles until a write with data bit 7 = 0 clears it.
- R3: The software detect bit drives `irq` only while `cd_chg_en` is 1. With `cd_chg_en` = 0 it causes no interrupt, even while it is set.
- R4: `rd_data[6]` and `rd_data[4:0]` always read 0, whatever value was written to those positions.
- R5: The `ireq_mode` encoding is: 2'b01 selects level mode, 2'b10 selects pulse mode, and 2'b00 and 2'b11 disable IREQ. While IREQ is disabled, `rd_data[5]` reads 0 and IREQ raises no interrupt.
- R6: In pulse mode with an I/O card, a falling edge on `card_ireq_n` sets `rd_data[5]`. The edge passes through a two-flop synchronizer, so the bit is visible after the third rising clock edge following the pin change. The bit stays set after the pin returns high.
- R7: In pulse mode, a write with data bit 5 = 0 clears `rd_data[5]`, and a write with data bit 5 = 1 leaves it unchanged.
- R8: In pulse mode, if a synchronized falling edge and a clearing write meet at the same clock edge, the bit ends up set.
- R9: In level mode with an I/O card, `rd_data[5]` equals the inverse of `card_ireq_n` delayed by two clock edges, and writes do not change it.
- R10: With `card_is_io` = 0, `rd_data[5]` reads 0 and no IREQ interrupt occurs in any mode. A pin edge seen during that time is not remembered later.
- R11: `irq` is the OR of (software detect bit AND `cd_chg_en`) and the visible IREQ bit.
- R12: Leaving pulse mode discards a latched IREQ request, so returning to pulse mode shows `rd_data[5]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| card_ireq_n | input | 1 | Card interrupt request pin, active low, asynchronous |
| card_is_io | input | 1 | 1 = I/O card interface, 0 = memory card interface |
| cd_chg_en | input | 1 | Card-detect-change interrupt enable |
| ireq_mode | input | 2 | IREQ mode: 01 level, 10 pulse, 00/11 disabled |
| irq | output | 1 | Card-status-change interrupt, active high |

## Verification
The hardest case to reach is the collision in which a synchronized pin edge and a software clear land on the same clock edge. The detected edge exists inside the block for only one cycle, two synchronizer stages after the pin moves. The bench first clears the bit. It then drops the pin on a falling clock edge, waits two rising edges, and raises the clearing write strobe so that the write meets the edge pulse. Finally it expects the bit to read 1.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int REG_W    = 8;
  localparam int SWCD_BIT = 7;
  localparam int RSV_BIT  = 6;
  localparam int IREQ_BIT = 5;

  typedef enum logic [1:0] {
    IRQM_OFF   = 2'b00,
    IRQM_LEVEL = 2'b01,
    IRQM_PULSE = 2'b10,
    IRQM_OFF_B = 2'b11
  } irq_mode_e;

  // Value shown at the IREQ position, given mode, interface type,
  // the latched request and the synchronized pin state (1 = pin low).
  function automatic logic ireq_view(irq_mode_e m, logic io, logic sticky,
                                     logic pin_low);
    logic v;
    v = 1'b0;
    if (io) begin
      if (m == IRQM_LEVEL) v = pin_low;
      else if (m == IRQM_PULSE) v = sticky;
    end
    return v;
  endfunction

  // Interrupt output from both sources.
  function automatic logic irq_merge(logic swcd, logic cd_en, logic ireq_vis);
    return (swcd & cd_en) | ireq_vis;
  endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n,
  output logic fall
);
  logic [STAGES:0] chain;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_n = chain[STAGES-1];
  assign fall   = chain[STAGES] & ~chain[STAGES-1];

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(sync_n)); // R6
endmodule

// File: rtl/csc_ireq_unit.sv
module csc_ireq_unit
  import csc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  logic      io,
  input  logic      sync_n,
  input  logic      fall,
  input  logic      clr_req,
  output logic      sticky,
  output logic      view
);
  logic pulse_live;
  logic set_ev;
  logic clr_ev;

  assign pulse_live = (mode == IRQM_PULSE) && io;
  assign set_ev     = pulse_live && fall;
  assign clr_ev     = pulse_live && clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sticky <= 1'b0;
    else if (!pulse_live) sticky <= 1'b0;
    else if (set_ev)      sticky <= 1'b1;
    else if (clr_ev)      sticky <= 1'b0;
  end

  assign view = ireq_view(mode, io, sticky, ~sync_n);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> sticky); // R8
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_live && sticky && !clr_req) |=> sticky); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !fall) |=> !sticky); // R7
  AST_LEAVE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_live |=> !sticky); // R12
  AST_LEVEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQM_LEVEL && io) |-> (view == !sync_n)); // R9
endmodule

// File: rtl/csc_swcd_unit.sv
module csc_swcd_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic swcd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     swcd <= 1'b0;
    else if (wr_en) swcd <= wr_bit;
  end

  AST_SWCD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=> swcd); // R2
  AST_SWCD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(swcd)); // R2
endmodule

// File: rtl/csc_status_reg.sv
module csc_status_reg
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             card_ireq_n,
  input  logic             card_is_io,
  input  logic             cd_chg_en,
  input  logic [1:0]       ireq_mode,
  output logic             irq
);
  irq_mode_e mode;
  logic      sync_n;
  logic      fall;
  logic      sticky;
  logic      ireq_vis;
  logic      swcd;
  logic      clr_req;
  logic      unused_wr;

  assign mode      = irq_mode_e'(ireq_mode);
  assign clr_req   = wr_en && !wr_data[IREQ_BIT];
  assign unused_wr = ^{wr_data[RSV_BIT], wr_data[4:0]};

  csc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(card_ireq_n),
    .sync_n(sync_n), .fall(fall)
  );

  csc_ireq_unit u_ireq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .io(card_is_io),
    .sync_n(sync_n), .fall(fall), .clr_req(clr_req),
    .sticky(sticky), .view(ireq_vis)
  );

  csc_swcd_unit u_swcd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bit(wr_data[SWCD_BIT]), .swcd(swcd)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[SWCD_BIT] = swcd;
    rd_data[IREQ_BIT] = ireq_vis;
  end

  assign irq = irq_merge(swcd, cd_chg_en, ireq_vis);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[RSV_BIT] == 1'b0) && (rd_data[4:0] == 5'd0)); // R4
  AST_MEM_NO_IREQ: assert property (@(posedge clk) disable iff (!rst_n)
    !card_is_io |-> !rd_data[IREQ_BIT]); // R10
  AST_OFF_NO_IREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQM_OFF || mode == IRQM_OFF_B) |-> !rd_data[IREQ_BIT]); // R5
  AST_SW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_chg_en && !ireq_vis) |-> !irq); // R3
endmodule

// File: tb/csc_status_reg_tb.sv
module csc_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       card_ireq_n = 1'b1;
  logic       card_is_io = 1'b1;
  logic       cd_chg_en = 1'b0;
  logic [1:0] ireq_mode = 2'b00;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  csc_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .card_ireq_n(card_ireq_n), .card_is_io(card_is_io),
    .cd_chg_en(cd_chg_en), .ireq_mode(ireq_mode), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic settle_pin_high();
    card_ireq_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    chk8("R1", rd_data, 8'h00);
    chk1("R1", irq, 1'b0);
  endtask

  task automatic t_swcd();
    cd_chg_en = 1'b0; ireq_mode = 2'b00;
    wr(8'h80);
    chk8("R2", rd_data, 8'h80);
    chk1("R3", irq, 1'b0);
    tick(3);
    chk8("R2", rd_data, 8'h80);
    cd_chg_en = 1'b1; tick(1);
    chk1("R3", irq, 1'b1);
    wr(8'h00);
    chk8("R2", rd_data, 8'h00);
    chk1("R11", irq, 1'b0);
    cd_chg_en = 1'b0;
  endtask

  task automatic t_reserved();
    ireq_mode = 2'b00;
    wr(8'hFF);
    chk8("R4", rd_data, 8'h80);
    wr(8'h5F);
    chk8("R4", rd_data, 8'h00);
  endtask

  task automatic t_pulse();
    ireq_mode = 2'b10; card_is_io = 1'b1; cd_chg_en = 1'b0;
    tick(1);
    card_ireq_n = 1'b0;
    tick(2);
    chk1("R6", rd_data[5], 1'b0);
    tick(1);
    chk1("R6", rd_data[5], 1'b1);
    chk1("R11", irq, 1'b1);
    card_ireq_n = 1'b1; tick(4);
    chk1("R6", rd_data[5], 1'b1);
    wr(8'h20);
    chk1("R7", rd_data[5], 1'b1);
    wr(8'h00);
    chk1("R7", rd_data[5], 1'b0);
    chk1("R7", irq, 1'b0);
  endtask

  task automatic t_set_wins();
    ireq_mode = 2'b10; card_is_io = 1'b1;
    settle_pin_high();
    wr(8'h00);
    chk1("R8", rd_data[5], 1'b0);
    card_ireq_n = 1'b0;
    tick(2);
    wr(8'h00);
    chk1("R8", rd_data[5], 1'b1);
    wr(8'h00);
    chk1("R8", rd_data[5], 1'b0);
    settle_pin_high();
  endtask

  task automatic t_level();
    ireq_mode = 2'b01; card_is_io = 1'b1;
    settle_pin_high();
    card_ireq_n = 1'b0;
    tick(1);
    chk1("R9", rd_data[5], 1'b0);
    tick(1);
    chk1("R9", rd_data[5], 1'b1);
    wr(8'h00);
    chk1("R9", rd_data[5], 1'b1);
    card_ireq_n = 1'b1;
    tick(2);
    chk1("R9", rd_data[5], 1'b0);
    chk1("R9", irq, 1'b0);
  endtask

  task automatic t_mode_off();
    card_is_io = 1'b1;
    ireq_mode = 2'b00;
    card_ireq_n = 1'b0; tick(4);
    chk1("R5", rd_data[5], 1'b0);
    chk1("R5", irq, 1'b0);
    ireq_mode = 2'b11; tick(1);
    chk1("R5", rd_data[5], 1'b0);
    chk1("R5", irq, 1'b0);
    settle_pin_high();
  endtask

  task automatic t_mem();
    card_is_io = 1'b0; ireq_mode = 2'b10;
    settle_pin_high();
    card_ireq_n = 1'b0; tick(4);
    chk1("R10", rd_data[5], 1'b0);
    chk1("R10", irq, 1'b0);
    card_is_io = 1'b1; tick(1);
    chk1("R10", rd_data[5], 1'b0);
    card_is_io = 1'b0; ireq_mode = 2'b01; tick(1);
    chk1("R10", rd_data[5], 1'b0);
    card_is_io = 1'b1;
    settle_pin_high();
  endtask

  task automatic t_leave_pulse();
    ireq_mode = 2'b10; card_is_io = 1'b1;
    card_ireq_n = 1'b0; tick(4);
    chk1("R12", rd_data[5], 1'b1);
    ireq_mode = 2'b00; tick(1);
    ireq_mode = 2'b10; tick(1);
    chk1("R12", rd_data[5], 1'b0);
    settle_pin_high();
  endtask

  task automatic t_irq_or();
    ireq_mode = 2'b10; card_is_io = 1'b1; cd_chg_en = 1'b1;
    wr(8'h80);
    card_ireq_n = 1'b0; tick(4);
    chk1("R11", irq, 1'b1);
    wr(8'h20);
    chk8("R11", rd_data, 8'h20);
    chk1("R11", irq, 1'b1);
    wr(8'h00);
    chk1("R11", irq, 1'b0);
    cd_chg_en = 1'b0;
    settle_pin_high();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_swcd();
    t_reserved();
    t_pulse();
    t_set_wins();
    t_level();
    t_mode_off();
    t_mem();
    t_leave_pulse();
    t_irq_or();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule